// File: doc/BRIEF.md
# Piecewise-linear temperature compensation calculator

This block converts an 8-bit digital temperature code into a signed correction term for an LCD drive supply. The correction follows a curve of four straight segments. Each segment has its own programmable slope, and the segments meet at fixed code knees at 20h, 40h and 60h. Fixed carry-in offsets keep the curve continuous across the knees, and code 40h is the zero-correction point. Below the first segment the curve is clamped to its value at code 0. Above the last segment it is clamped to its value at code 7Fh. A separate stage downstream adds the term into the total LCD voltage.

A new temperature sample is marked by a one-cycle strobe. On the next clock edge the block registers the correction word and raises a one-cycle valid pulse. Between strobes the word holds its value. One whole output step stands for 30 mV of LCD voltage deviation. Both the slopes and the result carry one fractional bit, so the resolution is half a step.

Top module: `tc_temp_comp`

## Requirements
- R1: While rst_n is low, corr_o reads 0 and valid_o reads 0.
- R2: valid_o is high for exactly the cycles that follow a cycle in which sample_i was high. A lone strobe gives a one-cycle pulse.
- R3: When sample_i is low, corr_o keeps its value. Changes on code_i or on any slope input during such cycles have no effect on corr_o.
- R4: For codes 21h to 40h, the registered result is (code − 64) × MB, so code 40h gives 0.
- R5: For codes 41h to 60h, the registered result is (code − 64) × MC.
- R6: For codes 01h to 20h, the registered result is (code − 32) × MA − 32 × MB.
- R7: For codes 61h to 7Eh, the registered result is (code − 96) × MD + 32 × MC.
- R8: Code 00h gives the lower clamp value −32 × MA − 32 × MB.
- R9: Every code from 7Fh to FFh gives the upper clamp value 31 × MD + 32 × MC.
- R10: Encoding and overflow. Each slope is a 5-bit two's-complement value with one fractional bit, so its raw code is twice the slope and ranges from −16 to 15. corr_o is a 12-bit two's-complement value with one fractional bit, with an LSB of half a step (15 mV). The raw output equals the formulas above evaluated on the raw slope codes. It is exact, with no wrap, for every code and every slope value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | 1 | Strobe marking a new temperature sample |
| code_i | input | 8 | Digital temperature code |
| ma_i | input | 5 | Slope of the segment 01h–20h (signed, 1 fractional bit) |
| mb_i | input | 5 | Slope of the segment 21h–40h (signed, 1 fractional bit) |
| mc_i | input | 5 | Slope of the segment 41h–60h (signed, 1 fractional bit) |
| md_i | input | 5 | Slope of the segment 61h–7Eh (signed, 1 fractional bit) |
| corr_o | output | 12 | Registered correction word (signed, 1 fractional bit) |
| valid_o | output | 1 | One-cycle pulse marking a new corr_o |

## Verification
The following are checked on every cycle: the strobe-to-valid timing, the hold of the correction word between strobes, the zero result at the centre knee, and the two clamp values at the ends of the curve. The exact value inside each of the four sloped segments, and the continuity at the knees, need the bench. Its sweeps cover every code against corner and uniform slope settings and compare each result with the segment formulas. The bench also shows that changes to the code or to the slopes without a strobe do not reach the output.

// File: rtl/tc_comp_pkg.sv
package tc_comp_pkg;
    // number of sloped segments on the curve
    localparam int TC_NSEG  = 4;
    localparam int TC_IDX_W = $clog2(TC_NSEG);
    typedef logic [TC_IDX_W-1:0] seg_idx_t;
endpackage

// File: rtl/tc_seg_decode.sv
module tc_seg_decode
    import tc_comp_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int SPAN   = 32
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] code_eff_o,
    output seg_idx_t          seg_o
);
    localparam int TOP = TC_NSEG * SPAN - 1;
    localparam int SH  = $clog2(SPAN);

    logic [CODE_W-1:0] clipped;
    logic [CODE_W-1:0] below;
    logic [CODE_W-1:0] shifted;

    always_comb begin
        // saturate above the last knee; code 0 falls into segment 0 naturally
        clipped = (code_i > CODE_W'(TOP)) ? CODE_W'(TOP) : code_i;
        below   = (clipped == '0) ? '0 : clipped - CODE_W'(1);
        shifted = below >> SH;
        code_eff_o = clipped;
        seg_o      = shifted[TC_IDX_W-1:0];
    end
endmodule

// File: rtl/tc_seg_term.sv
module tc_seg_term #(
    parameter int CODE_W  = 8,
    parameter int SLOPE_W = 5,
    parameter int OUT_W   = 12,
    parameter int BASE    = 64,
    parameter int CARRY   = 0
) (
    input  logic        [CODE_W-1:0]  code_i,
    input  logic signed [SLOPE_W-1:0] slope_i,
    input  logic signed [SLOPE_W-1:0] carry_slope_i,
    output logic signed [OUT_W-1:0]   term_o
);
    localparam int WW = OUT_W + 4;

    logic signed [WW-1:0] delta;
    logic signed [WW-1:0] slope_x;
    logic signed [WW-1:0] carry_x;
    logic signed [WW-1:0] prod;
    logic signed [WW-1:0] carry_term;
    logic signed [WW-1:0] sum;

    always_comb begin
        delta      = WW'(code_i) - WW'(BASE);
        slope_x    = WW'(slope_i);
        carry_x    = WW'(carry_slope_i);
        prod       = delta * slope_x;
        carry_term = carry_x * WW'(CARRY);
        sum        = prod + carry_term;
        term_o     = sum[OUT_W-1:0];
    end
endmodule

// File: rtl/tc_temp_comp.sv
module tc_temp_comp
    import tc_comp_pkg::*;
#(
    parameter int CODE_W  = 8,
    parameter int SLOPE_W = 5,
    parameter int OUT_W   = 12,
    parameter int SPAN    = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sample_i,
    input  logic        [CODE_W-1:0]  code_i,
    input  logic signed [SLOPE_W-1:0] ma_i,
    input  logic signed [SLOPE_W-1:0] mb_i,
    input  logic signed [SLOPE_W-1:0] mc_i,
    input  logic signed [SLOPE_W-1:0] md_i,
    output logic signed [OUT_W-1:0]   corr_o,
    output logic                      valid_o
);
    localparam int MID = TC_NSEG / 2;

    typedef struct packed {
        logic signed [OUT_W-1:0] corr;
        logic                    valid;
    } state_t;

    state_t st_d, st_q;

    logic [CODE_W-1:0]        code_eff;
    seg_idx_t                 seg;
    logic signed [SLOPE_W-1:0] slope_arr [TC_NSEG];
    logic signed [OUT_W-1:0]   term_arr  [TC_NSEG];

    assign slope_arr[0] = ma_i;
    assign slope_arr[1] = mb_i;
    assign slope_arr[2] = mc_i;
    assign slope_arr[3] = md_i;

    tc_seg_decode #(
        .CODE_W (CODE_W),
        .SPAN   (SPAN)
    ) dec_i (
        .code_i     (code_i),
        .code_eff_o (code_eff),
        .seg_o      (seg)
    );

    // Segments below the centre anchor at their upper end, those above at
    // their lower end; outer segments carry in the span of their neighbour.
    for (genvar k = 0; k < TC_NSEG; k++) begin : g_seg
        localparam int BASE_K  = (k < MID) ? SPAN * (k + 1) : SPAN * k;
        localparam int CARRY_K = (k < MID - 1) ? -SPAN :
                                 (k > MID)     ?  SPAN : 0;
        localparam int NB_K    = (k < MID - 1) ? k + 1 :
                                 (k > MID)     ? k - 1 : k;
        tc_seg_term #(
            .CODE_W  (CODE_W),
            .SLOPE_W (SLOPE_W),
            .OUT_W   (OUT_W),
            .BASE    (BASE_K),
            .CARRY   (CARRY_K)
        ) term_i (
            .code_i        (code_eff),
            .slope_i       (slope_arr[k]),
            .carry_slope_i (slope_arr[NB_K]),
            .term_o        (term_arr[k])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = sample_i;
        if (sample_i) begin
            st_d.corr = term_arr[seg];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign corr_o  = st_q.corr;
    assign valid_o = st_q.valid;
endmodule

// File: rtl/tc_comp_chk.sv
module tc_comp_chk #(
    parameter int CODE_W  = 8,
    parameter int SLOPE_W = 5,
    parameter int OUT_W   = 12
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      sample_i,
    input logic        [CODE_W-1:0]  code_i,
    input logic signed [SLOPE_W-1:0] ma_i,
    input logic signed [SLOPE_W-1:0] mb_i,
    input logic signed [SLOPE_W-1:0] mc_i,
    input logic signed [SLOPE_W-1:0] md_i,
    input logic signed [OUT_W-1:0]   corr_o,
    input logic                      valid_o
);
    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_zero_chk: assert (corr_o == '0 && !valid_o);
        end
    end

    // R2
    strobe_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_i |=> valid_o);

    // R2
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_i |=> !valid_o);

    // R3
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_i |=> $stable(corr_o));

    // R4
    centre_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_i && code_i == CODE_W'(64)) |=> (corr_o == '0));

    // R8
    floor_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_i && code_i == '0) |=>
        (int'(corr_o) == -32 * int'($past(ma_i)) - 32 * int'($past(mb_i))));

    // R9
    ceil_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_i && code_i >= CODE_W'(127)) |=>
        (int'(corr_o) == 31 * int'($past(md_i)) + 32 * int'($past(mc_i))));
endmodule

bind tc_temp_comp tc_comp_chk #(
    .CODE_W  (CODE_W),
    .SLOPE_W (SLOPE_W),
    .OUT_W   (OUT_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample_i (sample_i),
    .code_i   (code_i),
    .ma_i     (ma_i),
    .mb_i     (mb_i),
    .mc_i     (mc_i),
    .md_i     (md_i),
    .corr_o   (corr_o),
    .valid_o  (valid_o)
);

// File: tb/tc_temp_comp_tb.sv
module tc_temp_comp_tb_top;
    logic              clk = 1'b0;
    logic              rst_n;
    logic              sample_i;
    logic [7:0]        code_i;
    logic signed [4:0] ma_i, mb_i, mc_i, md_i;
    logic signed [11:0] corr_o;
    logic              valid_o;

    int checks = 0;
    int errors = 0;

    bit    pend = 1'b0;
    int    pend_exp = 0;
    string pend_tag = "";
    int    last_exp = 0;

    always #4 clk = ~clk;

    tc_temp_comp dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (sample_i),
        .code_i   (code_i),
        .ma_i     (ma_i),
        .mb_i     (mb_i),
        .mc_i     (mc_i),
        .md_i     (md_i),
        .corr_o   (corr_o),
        .valid_o  (valid_o)
    );

    function automatic int exp_corr(int c, int a, int b, int cc, int d);
        if (c == 0)        return -32 * a - 32 * b;
        else if (c <= 32)  return (c - 32) * a - 32 * b;
        else if (c <= 64)  return (c - 64) * b;
        else if (c <= 96)  return (c - 64) * cc;
        else if (c <= 126) return (c - 96) * d + 32 * cc;
        else               return 31 * d + 32 * cc;
    endfunction

    function automatic string tag_of(int c);
        if (c == 0)        return "R8";
        else if (c <= 32)  return "R6";
        else if (c <= 64)  return "R4";
        else if (c <= 96)  return "R5";
        else if (c <= 126) return "R7";
        else               return "R9";
    endfunction

    task automatic check(string tag, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // one cycle: check what the previous cycle produced, then drive new inputs
    task automatic step(bit s, int c, int a, int b, int cc, int d, string tag);
        @(negedge clk);
        if (pend) begin
            check({pend_tag, " value"}, int'(corr_o), pend_exp);
            check("R2 valid", int'(valid_o), 1);
        end
        sample_i = s;
        code_i   = 8'(c);
        ma_i     = 5'(a);
        mb_i     = 5'(b);
        mc_i     = 5'(cc);
        md_i     = 5'(d);
        pend     = s;
        if (s) begin
            pend_exp = exp_corr(c, a, b, cc, d);
            pend_tag = (tag == "") ? tag_of(c) : tag;
            last_exp = pend_exp;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        summary();
        $finish;
    end

    initial begin
        int corner [4] = '{-16, -1, 0, 15};
        rst_n = 1'b0;
        sample_i = 1'b0;
        code_i = '0;
        ma_i = '0; mb_i = '0; mc_i = '0; md_i = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 corr", int'(corr_o), 0);
        check("R1 valid", int'(valid_o), 0);
        sample_i = 1'b1;
        code_i = 8'h10; ma_i = 5'sd7;
        @(negedge clk);
        check("R1 corr held in reset", int'(corr_o), 0);
        check("R1 valid held in reset", int'(valid_o), 0);
        sample_i = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 corr after release", int'(corr_o), 0);

        // R2: lone strobe gives a one-cycle pulse
        step(1'b1, 8'h50, 0, 0, 3, 0, "R2 R5");
        step(1'b0, 8'h50, 0, 0, 3, 0, "");
        @(negedge clk);
        check("R2 pulse ends", int'(valid_o), 0);
        check("R2 value held", int'(corr_o), 48);

        // R3: no strobe, inputs change, output stays
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            sample_i = 1'b0;
            code_i = 8'(i * 70);
            ma_i = 5'(i - 8); mb_i = 5'(i + 3); mc_i = 5'(-i); md_i = 5'(15 - i);
            @(negedge clk);
            check("R3 corr unchanged", int'(corr_o), 48);
            check("R3 valid low", int'(valid_o), 0);
        end

        // corner slopes against every code, back to back
        for (int ia = 0; ia < 4; ia++)
            for (int ib = 0; ib < 4; ib++)
                for (int ic = 0; ic < 4; ic++)
                    for (int id = 0; id < 4; id++)
                        for (int c = 0; c < 256; c++)
                            step(1'b1, c, corner[ia], corner[ib], corner[ic], corner[id], "");

        // R10: every slope value, uniform across segments, every code
        for (int s = -16; s < 16; s++)
            for (int c = 0; c < 256; c++)
                step(1'b1, c, s, s, s, s, {"R10 ", tag_of(c)});

        // R10: extreme magnitudes at the ends
        step(1'b1, 0, -16, -16, 0, 0, "R10 R8 max");
        step(1'b1, 255, 0, 0, -16, -16, "R10 R9 min");
        step(1'b1, 127, 0, 0, 15, 15, "R10 R9 max");
        step(1'b0, 0, 0, 0, 0, 0, "");

        @(negedge clk);
        check("R3 final hold", int'(corr_o), last_exp);
        check("R2 final valid", int'(valid_o), 0);

        summary();
        $finish;
    end
endmodule